// File: doc/BRIEF.md
# Load-Linked Reservation Line Tracker

This block keeps the reservation state that a shared data cache needs for load-linked and store-conditional pairs issued by several requesters. A small direct-mapped table of line entries stands in for the cache's per-line lock bits. Each entry holds a valid bit, a line tag, a lock bit and the ID of the requester that owns the lock. The line index is taken from the address bits just above the 64-byte line offset, and the tag is taken from the bits above the index.

A request names an operation, a byte address, a requester ID and a line-present hint from the external tag lookup. The block answers each accepted request one cycle later with a success flag and a store-conditional result word. A load-linked request places a reservation. A store-conditional request consumes the reservation, whether it succeeds or fails. An ordinary store from the owner cancels the reservation. A separate invalidation port cancels the reservation when coherence permission for the line is lost. Allocate and evict inputs follow the fill and victim traffic of the cache.

Top module: `llsc_resv_tracker`

## Requirements
- R1: While reset is high, req_ready_o and rsp_valid_o are low, and reset clears every entry's valid bit and lock bit.
- R2: A load-linked request (op code 2) to a present line sets that line's lock, records req_id_i as the owner, and reports rsp_ok_o = 1.
- R3: A store-conditional request (op code 3) to a present line reports rsp_ok_o = 1 with rsp_word_o = 1 only when the line is locked and its owner equals req_id_i. Otherwise it reports rsp_ok_o = 0 with rsp_word_o = 0. Every request that is not a store-conditional returns rsp_word_o = 0.
- R4: Every store-conditional to a present line clears that line's lock, whether it succeeds or fails.
- R5: An ordinary store (op code 1) always reports rsp_ok_o = 1. It clears the line's lock only when the lock is held by the same req_id_i. An ordinary load (op code 0), or a store from another ID, leaves the lock unchanged.
- R6: A valid invalidation clears the lock of the entry whose index and tag match inv_addr_i. Other entries, and unlocked lines, are left unchanged.
- R7: A line is absent when req_present_i is low, when the indexed entry is not valid, or when its tag differs from the request's tag. A request to an absent line reports rsp_ok_o = 1, gives rsp_word_o = 1 for a store-conditional, and changes no lock.
- R8: When an invalidation and a request reach the same line in the same cycle, the invalidation is applied first. A store-conditional in that cycle therefore fails.
- R9: Outside reset, req_ready_o is high. Each accepted request produces exactly one rsp_valid_o pulse in the following cycle, and rsp_valid_o is low in every cycle that does not follow an accepted request.
- R10: An allocate writes the indexed entry as valid with a new tag and a clear lock. An evict whose tag matches clears the entry's valid bit and lock bit. Both override any request or invalidation to the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_op_i | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr_i | input | ADDR_W | Request byte address |
| req_id_i | input | ID_W | Requester ID |
| req_present_i | input | 1 | Tag lookup reports the line as present |
| inv_valid_i | input | 1 | Coherence permission lost for a line |
| inv_addr_i | input | ADDR_W | Address of the invalidated line |
| alloc_valid_i | input | 1 | Line filled into the table |
| alloc_addr_i | input | ADDR_W | Address of the filled line |
| evict_valid_i | input | 1 | Line removed from the table |
| evict_addr_i | input | ADDR_W | Address of the removed line |
| rsp_valid_o | output | 1 | Response pulse, one cycle after acceptance |
| rsp_ok_o | output | 1 | Request succeeded |
| rsp_word_o | output | WORD_W | Store-conditional result word (1 or 0) |

## Verification
Every response is due in the cycle after its request is accepted. The bench drives each stimulus at a falling edge and samples the flag and word at the next falling edge, which lies inside the response cycle. Lock, allocate, evict and invalidation updates take effect at the same rising edge as the response register, so a probe request issued in the next cycle sees the new state. Lock state cannot be read directly, so every change is checked through the result of a later store-conditional, and an idle cycle checks that the response pulse has dropped.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_line_table.sv
module llsc_line_table #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 23,
  parameter int ID_W    = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_lock,
  output logic [ID_W-1:0]  rd_owner,
  input  logic             wr_en,
  input  logic             wr_lock,
  input  logic [ID_W-1:0]  wr_owner,
  input  logic             inv_valid,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             alloc_valid,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             evict_valid,
  input  logic [IDX_W-1:0] evict_idx,
  input  logic [TAG_W-1:0] evict_tag
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] lock_q;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [ID_W-1:0]    owner_q [ENTRIES];
  logic               inv_here;

  // invalidation is applied before the request sees the entry
  assign inv_here = inv_valid && (inv_idx == rd_idx) && valid_q[rd_idx] && (tag_q[rd_idx] == inv_tag);
  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_lock  = lock_q[rd_idx] && !inv_here;
  assign rd_owner = owner_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      lock_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_valid && alloc_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= alloc_tag;
          lock_q[i]  <= 1'b0;
          owner_q[i] <= '0;
        end else if (evict_valid && evict_idx == IDX_W'(i) && valid_q[i] && tag_q[i] == evict_tag) begin
          valid_q[i] <= 1'b0;
          lock_q[i]  <= 1'b0;
        end else if (wr_en && rd_idx == IDX_W'(i)) begin
          lock_q[i]  <= wr_lock;
          owner_q[i] <= wr_owner;
        end else if (inv_valid && inv_idx == IDX_W'(i) && valid_q[i] && tag_q[i] == inv_tag) begin
          lock_q[i]  <= 1'b0;
        end
      end
    end
  end

  // R1: reset leaves no entry valid or locked
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lock_q == '0 && valid_q == '0));

  // R10: an allocate always leaves its entry valid and unlocked
  p_alloc_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alloc_valid)) |-> (valid_q[$past(alloc_idx)] && !lock_q[$past(alloc_idx)]));

  // R6: a lock is never set without a write from the request path
  p_lock_only_by_req_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> ((lock_q & ~$past(lock_q)) == '0));
endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
  import llsc_pkg::*;
#(
  parameter int TAG_W = 23,
  parameter int ID_W  = 2
) (
  input  logic [1:0]       op,
  input  logic [ID_W-1:0]  id,
  input  logic             present,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             rd_lock,
  input  logic [ID_W-1:0]  rd_owner,
  output logic             ok,
  output logic             wr_en,
  output logic             wr_lock,
  output logic [ID_W-1:0]  wr_owner
);
  llsc_op_e op_e;
  logic     hit;
  logic     owned;

  assign op_e  = llsc_op_e'(op);
  assign hit   = present && rd_valid && (rd_tag == req_tag);
  assign owned = rd_lock && (rd_owner == id);

  always_comb begin
    ok       = 1'b1;
    wr_en    = 1'b0;
    wr_lock  = rd_lock;
    wr_owner = rd_owner;
    case (op_e)
      OP_LL: if (hit) begin
        wr_en    = 1'b1;
        wr_lock  = 1'b1;
        wr_owner = id;
      end
      OP_SC: if (hit) begin
        ok      = owned;
        wr_en   = 1'b1;
        wr_lock = 1'b0;
      end
      OP_STORE: if (hit && owned) begin
        wr_en   = 1'b1;
        wr_lock = 1'b0;
      end
      default: ;
    endcase
  end

  // R3: only a store-conditional can fail
  always_comb begin
    if (!ok) a_fail_only_sc_r3: assert (op_e == OP_SC);
  end
endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker
  import llsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 8,
  parameter int ID_W       = 2,
  parameter int WORD_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic              req_present_i,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic [WORD_W-1:0] rsp_word_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic             fire;
  logic             rd_valid, rd_lock, ok, wr_en, wr_lock;
  logic [TAG_W-1:0] rd_tag;
  logic [ID_W-1:0]  rd_owner, wr_owner;
  logic [1:0]       rsp_op_q;
  logic             unused_offsets;

  assign unused_offsets = ^{req_addr_i[OFF_W-1:0], inv_addr_i[OFF_W-1:0],
                            alloc_addr_i[OFF_W-1:0], evict_addr_i[OFF_W-1:0]};
  assign req_ready_o = !rst;
  assign fire        = req_valid_i && req_ready_o;

  llsc_line_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ID_W(ID_W)) u_table (
    .clk         (clk),
    .rst         (rst),
    .rd_idx      (req_addr_i[OFF_W +: IDX_W]),
    .rd_valid    (rd_valid),
    .rd_tag      (rd_tag),
    .rd_lock     (rd_lock),
    .rd_owner    (rd_owner),
    .wr_en       (wr_en && fire),
    .wr_lock     (wr_lock),
    .wr_owner    (wr_owner),
    .inv_valid   (inv_valid_i),
    .inv_idx     (inv_addr_i[OFF_W +: IDX_W]),
    .inv_tag     (inv_addr_i[ADDR_W-1 -: TAG_W]),
    .alloc_valid (alloc_valid_i),
    .alloc_idx   (alloc_addr_i[OFF_W +: IDX_W]),
    .alloc_tag   (alloc_addr_i[ADDR_W-1 -: TAG_W]),
    .evict_valid (evict_valid_i),
    .evict_idx   (evict_addr_i[OFF_W +: IDX_W]),
    .evict_tag   (evict_addr_i[ADDR_W-1 -: TAG_W])
  );

  llsc_decide #(.TAG_W(TAG_W), .ID_W(ID_W)) u_decide (
    .op       (req_op_i),
    .id       (req_id_i),
    .present  (req_present_i),
    .req_tag  (req_addr_i[ADDR_W-1 -: TAG_W]),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_lock  (rd_lock),
    .rd_owner (rd_owner),
    .ok       (ok),
    .wr_en    (wr_en),
    .wr_lock  (wr_lock),
    .wr_owner (wr_owner)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_word_o  <= '0;
      rsp_op_q    <= 2'd0;
    end else begin
      rsp_valid_o <= fire;
      if (fire) begin
        rsp_ok_o   <= ok;
        rsp_word_o <= WORD_W'((req_op_i == OP_SC) && ok);
        rsp_op_q   <= req_op_i;
      end
    end
  end

  // R9: a response pulse only follows an accepted request
  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o));

  // R2: load-linked always reports success
  p_ll_ok_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_op_q == OP_LL) |-> rsp_ok_o);

  // R3: result word mirrors the store-conditional outcome, zero otherwise
  p_sc_word_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> (rsp_word_o == WORD_W'((rsp_op_q == OP_SC) && rsp_ok_o)));

  // R5: ordinary stores always report success
  p_store_ok_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_op_q == OP_STORE) |-> rsp_ok_o);
endmodule

// File: tb/sim_llsc_resv_tracker.sv
`timescale 1ns/1ps
module sim_llsc_resv_tracker;
  import llsc_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid_i, req_ready_o, req_present_i;
  logic [1:0]  req_op_i;
  logic [31:0] req_addr_i, inv_addr_i, alloc_addr_i, evict_addr_i;
  logic [1:0]  req_id_i;
  logic        inv_valid_i, alloc_valid_i, evict_valid_i;
  logic        rsp_valid_o, rsp_ok_o;
  logic [31:0] rsp_word_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit          mv [8];
  bit          ml [8];
  logic [22:0] mt [8];
  logic [1:0]  mo [8];

  always #2.5 clk = ~clk;

  llsc_resv_tracker u0 (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_id_i(req_id_i),
    .req_present_i(req_present_i), .inv_valid_i(inv_valid_i), .inv_addr_i(inv_addr_i),
    .alloc_valid_i(alloc_valid_i), .alloc_addr_i(alloc_addr_i),
    .evict_valid_i(evict_valid_i), .evict_addr_i(evict_addr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ok_o(rsp_ok_o), .rsp_word_o(rsp_word_o)
  );

  function automatic logic [31:0] mk(int tg, int ix);
    return (32'(tg) << 9) | (32'(ix) << 6) | 32'd5;
  endfunction

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic clr_in();
    req_valid_i = 0; req_op_i = 0; req_addr_i = 0; req_id_i = 0; req_present_i = 0;
    inv_valid_i = 0; inv_addr_i = 0; alloc_valid_i = 0; alloc_addr_i = 0;
    evict_valid_i = 0; evict_addr_i = 0;
  endtask

  task automatic req(logic [1:0] op, int tg, int ix, int id, bit pres = 1'b1);
    req_valid_i = 1; req_op_i = op; req_addr_i = mk(tg, ix); req_id_i = 2'(id); req_present_i = pres;
  endtask
  task automatic inv(int tg, int ix);   inv_valid_i = 1;   inv_addr_i = mk(tg, ix);   endtask
  task automatic alloc(int tg, int ix); alloc_valid_i = 1; alloc_addr_i = mk(tg, ix); endtask
  task automatic evict(int tg, int ix); evict_valid_i = 1; evict_addr_i = mk(tg, ix); endtask

  // applies the driven cycle to the model, waits one cycle, checks the response
  task automatic go(string r);
    int   ri, ii;
    bit   inv_hit, elock, hit, owned, eok, wr, nl, rv;
    logic [1:0] no;
    int   eword;
    ri = int'(req_addr_i[8:6]);
    ii = int'(inv_addr_i[8:6]);
    inv_hit = inv_valid_i && ii == ri && mv[ri] && mt[ri] == inv_addr_i[31:9];
    elock = ml[ri] && !inv_hit;
    hit   = req_present_i && mv[ri] && mt[ri] == req_addr_i[31:9];
    owned = elock && mo[ri] == req_id_i;
    eok = 1; wr = 0; nl = elock; no = mo[ri];
    case (req_op_i)
      2'd2: if (hit) begin wr = 1; nl = 1; no = req_id_i; end
      2'd3: if (hit) begin eok = owned; wr = 1; nl = 0; end
      2'd1: if (hit && owned) begin wr = 1; nl = 0; end
      default: ;
    endcase
    eword = (req_op_i == 2'd3 && eok) ? 1 : 0;
    rv = req_valid_i;
    for (int i = 0; i < 8; i++) begin
      if (alloc_valid_i && int'(alloc_addr_i[8:6]) == i) begin
        mv[i] = 1; mt[i] = alloc_addr_i[31:9]; ml[i] = 0; mo[i] = 0;
      end else if (evict_valid_i && int'(evict_addr_i[8:6]) == i && mv[i] && mt[i] == evict_addr_i[31:9]) begin
        mv[i] = 0; ml[i] = 0;
      end else if (rv && wr && ri == i) begin
        ml[i] = nl; mo[i] = no;
      end else if (inv_valid_i && ii == i && mv[i] && mt[i] == inv_addr_i[31:9]) begin
        ml[i] = 0;
      end
    end
    @(negedge clk);
    chk(r, "rsp_valid", int'(rsp_valid_o), int'(rv));
    if (rv) begin
      chk(r, "rsp_ok", int'(rsp_ok_o), int'(eok));
      chk(r, "rsp_word", int'(rsp_word_o), eword);
    end
    clr_in();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin mv[i] = 0; ml[i] = 0; mt[i] = 0; mo[i] = 0; end
    clr_in();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(req_ready_o), 0);
    chk("R1", "rsp_valid in reset", int'(rsp_valid_o), 0);
    rst = 0;
    #0.1;
    chk("R9", "ready after reset", int'(req_ready_o), 1);

    // R1 / R7: nothing valid after reset, so a store-conditional sees an absent line
    req(OP_SC, 5, 1, 1); go("R1");
    chk("R7", "sc absent word", int'(rsp_word_o), 1);

    alloc(5, 1); go("R10");
    alloc(7, 2); go("R10");
    req(OP_SC, 5, 1, 1); go("R1");
    chk("R1", "sc on fresh line fails", int'(rsp_ok_o), 0);

    // R2 / R3 / R4
    req(OP_LL, 5, 1, 1); go("R2");
    chk("R2", "ll ok", int'(rsp_ok_o), 1);
    req(OP_SC, 5, 1, 1); go("R3");
    chk("R3", "sc owned word", int'(rsp_word_o), 1);
    req(OP_SC, 5, 1, 1); go("R4");
    chk("R4", "second sc word", int'(rsp_word_o), 0);
    req(OP_LL, 5, 1, 1); go("R2");
    req(OP_SC, 5, 1, 2); go("R3");
    chk("R3", "sc other id fails", int'(rsp_ok_o), 0);
    req(OP_SC, 5, 1, 1); go("R4");
    chk("R4", "failed sc cleared lock", int'(rsp_ok_o), 0);

    // R5
    req(OP_LL, 5, 1, 1); go("R5");
    req(OP_STORE, 5, 1, 2); go("R5");
    req(OP_LOAD, 5, 1, 1); go("R5");
    chk("R5", "load word zero", int'(rsp_word_o), 0);
    req(OP_SC, 5, 1, 1); go("R5");
    chk("R5", "lock kept over other store and load", int'(rsp_ok_o), 1);
    req(OP_LL, 5, 1, 1); go("R5");
    req(OP_STORE, 5, 1, 1); go("R5");
    chk("R5", "own store ok", int'(rsp_ok_o), 1);
    req(OP_SC, 5, 1, 1); go("R5");
    chk("R5", "own store cleared lock", int'(rsp_ok_o), 0);

    // R6
    req(OP_LL, 5, 1, 0); go("R6");
    inv(5, 1); go("R6");
    req(OP_SC, 5, 1, 0); go("R6");
    chk("R6", "invalidated lock", int'(rsp_ok_o), 0);
    req(OP_LL, 5, 1, 0); go("R6");
    inv(7, 2); go("R6");
    req(OP_SC, 5, 1, 0); go("R6");
    chk("R6", "other line inv leaves lock", int'(rsp_ok_o), 1);

    // R7
    req(OP_LL, 5, 1, 3); go("R7");
    req(OP_SC, 5, 1, 3, 1'b0); go("R7");
    chk("R7", "absent sc ok", int'(rsp_ok_o), 1);
    req(OP_SC, 6, 1, 3); go("R7");
    chk("R7", "tag mismatch sc word", int'(rsp_word_o), 1);
    req(OP_SC, 5, 1, 3); go("R7");
    chk("R7", "lock untouched by absent requests", int'(rsp_ok_o), 1);

    // R8
    req(OP_LL, 7, 2, 2); go("R8");
    req(OP_SC, 7, 2, 2); inv(7, 2); go("R8");
    chk("R8", "sc with same-cycle inv", int'(rsp_ok_o), 0);

    // R9: idle cycle
    go("R9");
    chk("R9", "no pulse when idle", int'(rsp_valid_o), 0);

    // R10
    req(OP_LL, 5, 1, 1); go("R10");
    alloc(5, 1); go("R10");
    req(OP_SC, 5, 1, 1); go("R10");
    chk("R10", "realloc clears lock", int'(rsp_ok_o), 0);
    req(OP_LL, 5, 1, 1); go("R10");
    evict(5, 1); go("R10");
    req(OP_SC, 5, 1, 1); go("R10");
    chk("R10", "evicted line absent", int'(rsp_word_o), 1);
    alloc(5, 1); req(OP_LL, 5, 1, 1); go("R10");
    req(OP_SC, 5, 1, 1); go("R10");
    chk("R10", "alloc overrides same-cycle ll", int'(rsp_ok_o), 0);

    // constrained random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 10) < 8)
        req(2'($urandom % 4), int'($urandom % 2), int'($urandom % 8), int'($urandom % 4),
            (($urandom % 10) != 0));
      if (($urandom % 10) == 0) inv(int'($urandom % 2), int'($urandom % 8));
      if (($urandom % 20) == 0) alloc(int'($urandom % 2), int'($urandom % 8));
      if (($urandom % 30) == 0) evict(int'($urandom % 2), int'($urandom % 8));
      go("R3");
    end

    finish_run();
  end
endmodule